// File: doc/BRIEF.md
# Endpoint Buffer Data Port

This block sits between a local microcontroller and the two packet buffers of one endpoint. Through a single 16-bit data-port register the microcontroller loads bytes into the transmit buffer of an IN endpoint, or unloads bytes from the receive buffer of an OUT endpoint. Each access moves one byte (8-bit access, low lane only) or two bytes (16-bit access, little-endian: low lane holds the lower-addressed byte).

The transmit side counts loaded bytes against a programmable maximum packet size. It marks the buffer ready for transmission on its own when that size is reached. A validate command can mark a shorter packet ready. The receive side counts bytes as the microcontroller reads them and empties the buffer on its own after the last one. A clear command can empty it at any time. The serial engine is modelled by strobes: a `txSent` pulse consumes a ready transmit packet, and the receiver pushes bytes with `rxByteWr` and closes a packet with `rxPktDone`. It reads transmit bytes through a peek index.

Top module: `epDataPort`

## Requirements
- R1: After reset `txCount`=0, `txValid`=0, `txOverrun`=0, `rxFull`=0, `rxLeft`=0 and `rdData`=0.
- R2: A transmit load with `wideAcc`=1 stores `wrData[7:0]` at index `txCount` and `wrData[15:8]` at `txCount`+1, and adds 2 to `txCount`. With `wideAcc`=0 it stores only `wrData[7:0]` at `txCount`, ignores `wrData[15:8]`, and adds 1.
- R3: When a load brings `txCount` to the latched maximum packet size, `txValid` goes to 1 with the same clock edge.
- R4: `validateCmd` sets `txValid` when the byte count is short. A `txSent` pulse while `txValid`=1 clears `txValid` and returns `txCount` to 0.
- R5: A load while `txValid`=1 changes no byte and no count. `txOverrun` is 1 for exactly the cycle after it.
- R6: A 16-bit load with one byte of room left stores only `wrData[7:0]`, adds 1, and validates the buffer.
- R7: A `rxByteWr` byte is stored at index `rxLeft` only while `rxFull`=0 and fewer than the latched maximum packet size bytes are held. `rxPktDone` with at least one byte held sets `rxFull`. Bytes offered while full or beyond the size are dropped.
- R8: A read with `rxFull`=1 places the next byte in `rdData[7:0]` in the cycle after `rdEn`. A 16-bit read places the following byte in `rdData[15:8]` and subtracts 2 from `rxLeft`. An 8-bit read sets `rdData[15:8]`=0 and subtracts 1.
- R9: The read that takes the last byte clears `rxFull` and `rxLeft`. A 16-bit read with one byte left returns that byte with `rdData[15:8]`=0.
- R10: A read while `rxFull`=0 returns `rdData`=0 and changes neither `rxLeft` nor `rxFull`.
- R11: `clearCmd` clears `rxFull` and `rxLeft` in one cycle and leaves `txCount` and `txValid` unchanged.
- R12: `mpsIn` is latched separately for each buffer, only while that buffer is empty. A change during filling does not move that packet's full point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mpsIn | input | 10 | Maximum packet size in bytes |
| wideAcc | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| wrEn | input | 1 | Data-port write (transmit load) |
| wrData | input | 16 | Data-port write value |
| rdEn | input | 1 | Data-port read (receive unload) |
| rdData | output | 16 | Read value, registered |
| validateCmd | input | 1 | Force transmit buffer ready |
| clearCmd | input | 1 | Force receive buffer empty |
| txSent | input | 1 | Serial engine has sent the ready packet |
| txPeekIdx | input | 10 | Serial engine byte index into transmit buffer |
| txPeekByte | output | 8 | Transmit byte at `txPeekIdx` |
| rxByteWr | input | 1 | Serial engine pushes a received byte |
| rxByte | input | 8 | Received byte |
| rxPktDone | input | 1 | Received packet complete |
| txCount | output | 10 | Bytes loaded in transmit buffer |
| txValid | output | 1 | Transmit buffer ready to send |
| txOverrun | output | 1 | Pulse: load refused because buffer was ready |
| rxFull | output | 1 | Receive buffer holds an unread packet |
| rxLeft | output | 10 | Received bytes not yet read |

## Verification
The bench targets the packet edges. A 16-bit load or read with one byte left must move only one byte; a design that stepped by two would overrun the size and never validate, or would return a stale upper byte. It loads into a ready buffer and changes the size mid-fill: a design that accepted the load would corrupt a queued packet, and one that resampled the size would validate early. It also reads from an empty buffer, sends a zero-byte done and forces a clear. A wrong design here would return stale data, hang full with nothing to read, or disturb the transmit count.

// File: rtl/epDataPortPkg.sv
package epDataPortPkg;
  typedef struct packed {
    logic txWrLo;
    logic txWrHi;
    logic rxWr;
    logic rdLo;
    logic rdHi;
    logic rdZero;
  } portStrb_t;
endpackage

// File: rtl/epPortCtrl.sv
module epPortCtrl
  import epDataPortPkg::*;
#(
  parameter int MPS_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MPS_W-1:0] mpsIn,
  input  logic             wideAcc,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             validateCmd,
  input  logic             clearCmd,
  input  logic             txSent,
  input  logic             rxByteWr,
  input  logic             rxPktDone,
  output portStrb_t        strb,
  output logic [MPS_W-1:0] txAddr,
  output logic [MPS_W-1:0] rxWAddr,
  output logic [MPS_W-1:0] rdAddr,
  output logic [MPS_W-1:0] txCount,
  output logic             txValid,
  output logic             txOverrun,
  output logic             rxFull,
  output logic [MPS_W-1:0] rxLeft
);
  localparam logic [MPS_W-1:0] ONE = MPS_W'(1);
  localparam logic [MPS_W-1:0] TWO = MPS_W'(2);

  logic [MPS_W-1:0] txMps, rxMps, rxLen, rdPtr;
  logic [MPS_W-1:0] txRoom, txNext, rxRemain, rdNext;
  logic txAccept, txTwo, rxAccept, rdAccept, rdTwo, txEmpty, rxEmpty;

  assign txEmpty  = !txValid && (txCount == '0);
  assign rxEmpty  = !rxFull && (rxLen == '0);
  assign txRoom   = txMps - txCount;
  assign txTwo    = wideAcc && (txRoom >= TWO);
  assign txAccept = wrEn && !txValid;
  assign txNext   = txCount + (txTwo ? TWO : ONE);

  assign rxRemain = rxLen - rdPtr;
  assign rxAccept = rxByteWr && !rxFull && (rxLen < rxMps);
  assign rdAccept = rdEn && rxFull && !clearCmd;
  assign rdTwo    = wideAcc && (rxRemain >= TWO);
  assign rdNext   = rdPtr + (rdTwo ? TWO : ONE);

  always_comb begin
    strb        = '0;
    strb.txWrLo = txAccept;
    strb.txWrHi = txAccept && txTwo;
    strb.rxWr   = rxAccept;
    strb.rdLo   = rdAccept;
    strb.rdHi   = rdAccept && rdTwo;
    strb.rdZero = rdEn && !rdAccept;
  end

  assign txAddr  = txCount;
  assign rxWAddr = rxLen;
  assign rdAddr  = rdPtr;
  assign rxLeft  = rxRemain;

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCount   <= '0;
      txValid   <= 1'b0;
      txOverrun <= 1'b0;
      txMps     <= '0;
    end else begin
      txOverrun <= wrEn && txValid;
      if (txEmpty) txMps <= mpsIn;
      if (txSent && txValid) begin
        txValid <= 1'b0;
        txCount <= '0;
      end else begin
        if (txAccept) begin
          txCount <= txNext;
          if (txNext >= txMps) txValid <= 1'b1;
        end
        if (validateCmd) txValid <= 1'b1;
      end
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxLen  <= '0;
      rdPtr  <= '0;
      rxMps  <= '0;
    end else begin
      if (rxEmpty) rxMps <= mpsIn;
      if (clearCmd) begin
        rxFull <= 1'b0;
        rxLen  <= '0;
        rdPtr  <= '0;
      end else if (rdAccept) begin
        if (rdNext == rxLen) begin
          rxFull <= 1'b0;
          rxLen  <= '0;
          rdPtr  <= '0;
        end else begin
          rdPtr <= rdNext;
        end
      end else if (!rxFull) begin
        if (rxAccept) rxLen <= rxLen + ONE;
        if (rxPktDone && (rxLen != '0 || rxAccept)) rxFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/epPortData.sv
module epPortData
  import epDataPortPkg::*;
#(
  parameter int MPS_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrb_t        strb,
  input  logic [MPS_W-1:0] txAddr,
  input  logic [15:0]      wrData,
  input  logic [MPS_W-1:0] txPeekIdx,
  output logic [7:0]       txPeekByte,
  input  logic [MPS_W-1:0] rxWAddr,
  input  logic [7:0]       rxByte,
  input  logic [MPS_W-1:0] rdAddr,
  output logic [15:0]      rdData
);
  localparam int DEPTH = 1 << MPS_W;

  logic [7:0] txMem [DEPTH];
  logic [7:0] rxMem [DEPTH];
  logic [MPS_W-1:0] txHiAddr, rdHiAddr;

  assign txHiAddr = txAddr + MPS_W'(1);
  assign rdHiAddr = rdAddr + MPS_W'(1);

  always_ff @(posedge clk) begin
    if (strb.txWrLo) txMem[txAddr]   <= wrData[7:0];
    if (strb.txWrHi) txMem[txHiAddr] <= wrData[15:8];
    if (strb.rxWr)   rxMem[rxWAddr]  <= rxByte;
  end

  assign txPeekByte = txMem[txPeekIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdLo) begin
      rdData[7:0]  <= rxMem[rdAddr];
      rdData[15:8] <= strb.rdHi ? rxMem[rdHiAddr] : 8'h00;
    end else if (strb.rdZero) begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/epDataPort.sv
module epDataPort
  import epDataPortPkg::*;
#(
  parameter int MPS_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MPS_W-1:0] mpsIn,
  input  logic             wideAcc,
  input  logic             wrEn,
  input  logic [15:0]      wrData,
  input  logic             rdEn,
  output logic [15:0]      rdData,
  input  logic             validateCmd,
  input  logic             clearCmd,
  input  logic             txSent,
  input  logic [MPS_W-1:0] txPeekIdx,
  output logic [7:0]       txPeekByte,
  input  logic             rxByteWr,
  input  logic [7:0]       rxByte,
  input  logic             rxPktDone,
  output logic [MPS_W-1:0] txCount,
  output logic             txValid,
  output logic             txOverrun,
  output logic             rxFull,
  output logic [MPS_W-1:0] rxLeft
);
  portStrb_t        strb;
  logic [MPS_W-1:0] txAddr, rxWAddr, rdAddr;

  epPortCtrl #(.MPS_W(MPS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mpsIn(mpsIn), .wideAcc(wideAcc),
    .wrEn(wrEn), .rdEn(rdEn), .validateCmd(validateCmd),
    .clearCmd(clearCmd), .txSent(txSent), .rxByteWr(rxByteWr),
    .rxPktDone(rxPktDone), .strb(strb), .txAddr(txAddr),
    .rxWAddr(rxWAddr), .rdAddr(rdAddr), .txCount(txCount),
    .txValid(txValid), .txOverrun(txOverrun), .rxFull(rxFull),
    .rxLeft(rxLeft)
  );

  epPortData #(.MPS_W(MPS_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txAddr(txAddr),
    .wrData(wrData), .txPeekIdx(txPeekIdx), .txPeekByte(txPeekByte),
    .rxWAddr(rxWAddr), .rxByte(rxByte), .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/epDataPortChk.sv
module epDataPortChk #(
  parameter int MPS_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             validateCmd,
  input logic             clearCmd,
  input logic             txSent,
  input logic [15:0]      rdData,
  input logic [MPS_W-1:0] txCount,
  input logic             txValid,
  input logic             txOverrun,
  input logic             rxFull,
  input logic [MPS_W-1:0] rxLeft
);
  p_sent_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txSent && txValid) |=> (!txValid && txCount == '0));

  p_ignored_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txValid && !txSent) |=> (txOverrun && $stable(txCount)));

  p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    txOverrun |-> ($past(wrEn) && $past(txValid)));

  p_valid_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> ($past(wrEn) || $past(validateCmd)));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rxFull) |=> (rdData == 16'h0000));

  p_force_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (!rxFull && rxLeft == '0));

  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rdEn && !clearCmd) |=> (rxFull && $stable(rxLeft)));
endmodule

bind epDataPort epDataPortChk #(.MPS_W(MPS_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .validateCmd(validateCmd), .clearCmd(clearCmd), .txSent(txSent),
  .rdData(rdData), .txCount(txCount), .txValid(txValid),
  .txOverrun(txOverrun), .rxFull(rxFull), .rxLeft(rxLeft)
);

// File: tb/tb_epDataPort.sv
module tb_epDataPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] mpsIn = 10'd5;
  logic wideAcc = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic validateCmd = 1'b0, clearCmd = 1'b0, txSent = 1'b0;
  logic [9:0] txPeekIdx = '0;
  logic rxByteWr = 1'b0, rxPktDone = 1'b0;
  logic [7:0] rxByte = '0;
  logic [15:0] rdData;
  logic [7:0] txPeekByte;
  logic [9:0] txCount, rxLeft;
  logic txValid, txOverrun, rxFull;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  epDataPort dut (
    .clk(clk), .rstN(rstN), .mpsIn(mpsIn), .wideAcc(wideAcc),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .validateCmd(validateCmd), .clearCmd(clearCmd), .txSent(txSent),
    .txPeekIdx(txPeekIdx), .txPeekByte(txPeekByte), .rxByteWr(rxByteWr),
    .rxByte(rxByte), .rxPktDone(rxPktDone), .txCount(txCount),
    .txValid(txValid), .txOverrun(txOverrun), .rxFull(rxFull),
    .rxLeft(rxLeft)
  );

  // op: 0 load, 1 validate, 2 sent | wide | data | expCount | expValid | expOverrun
  localparam logic [30:0] VEC [12] = '{
    {2'd0, 1'b1, 16'hA1B2, 10'd2, 1'b0, 1'b0},
    {2'd0, 1'b0, 16'hFFC3, 10'd3, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'hD4E5, 10'd5, 1'b1, 1'b0},
    {2'd0, 1'b1, 16'h1111, 10'd5, 1'b1, 1'b1},
    {2'd2, 1'b0, 16'h0000, 10'd0, 1'b0, 1'b0},
    {2'd0, 1'b0, 16'hEE77, 10'd1, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0000, 10'd1, 1'b1, 1'b0},
    {2'd2, 1'b0, 16'h0000, 10'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'h2233, 10'd2, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'h4455, 10'd4, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'h6677, 10'd5, 1'b1, 1'b0},
    {2'd2, 1'b0, 16'h0000, 10'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wrEn = 0; rdEn = 0; validateCmd = 0; clearCmd = 0; txSent = 0;
    rxByteWr = 0; rxPktDone = 0;
  endtask

  task automatic load(input logic w, input logic [15:0] d);
    wideAcc = w; wrData = d; wrEn = 1; step();
  endtask

  task automatic rd(input logic w);
    wideAcc = w; rdEn = 1; step();
  endtask

  task automatic push(input logic [7:0] b);
    rxByte = b; rxByteWr = 1; step();
  endtask

  task automatic peek(input string req, input int idx, input logic [7:0] exp);
    txPeekIdx = 10'(idx); #1;
    check(req, 32'(txPeekByte), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    check("R1 txCount", 32'(txCount), 0);
    check("R1 txValid", 32'(txValid), 0);
    check("R1 txOverrun", 32'(txOverrun), 0);
    check("R1 rxFull", 32'(rxFull), 0);
    check("R1 rxLeft", 32'(rxLeft), 0);
    check("R1 rdData", 32'(rdData), 0);

    // vector table walk, mps = 5 (R2 R3 R4 R5 R6)
    for (int i = 0; i < 12; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wideAcc = v[28]; wrData = v[27:12];
      case (v[30:29])
        2'd0: wrEn = 1;
        2'd1: validateCmd = 1;
        default: txSent = 1;
      endcase
      step();
      check($sformatf("R2/R3/R4/R6 vec%0d count", i), 32'(txCount), 32'(v[11:2]));
      check($sformatf("R3/R4 vec%0d valid", i), 32'(txValid), 32'(v[1]));
      check($sformatf("R5 vec%0d overrun", i), 32'(txOverrun), 32'(v[0]));
    end
    peek("R2 byte0", 0, 8'h33);
    peek("R2 byte1", 1, 8'h22);
    peek("R2 byte2", 2, 8'h55);
    peek("R2 byte3", 3, 8'h44);
    peek("R6 byte4 low only", 4, 8'h77);

    // R2: 8-bit load ignores upper lane
    load(1'b0, 16'hEE42);
    check("R2 8-bit count", 32'(txCount), 1);
    peek("R2 8-bit low", 0, 8'h42);
    peek("R2 8-bit upper ignored", 1, 8'h22);

    // R12: size change mid-fill is not seen until empty
    mpsIn = 10'd2;
    load(1'b0, 16'h0001);
    check("R12 no early valid", 32'(txValid), 0);
    check("R12 count", 32'(txCount), 2);
    validateCmd = 1; step();
    check("R4 short validate", 32'(txValid), 1);
    txSent = 1; step();
    step();
    load(1'b1, 16'hBEEF);
    check("R12 new size valid", 32'(txValid), 1);
    check("R12 new size count", 32'(txCount), 2);
    txSent = 1; step();
    load(1'b0, 16'h0009);
    check("R11 tx setup count", 32'(txCount), 1);

    // receive side with size 4
    mpsIn = 10'd4; step();
    push(8'h10); push(8'h11); push(8'h12); push(8'h13); push(8'h14);
    check("R7 size limit", 32'(rxLeft), 4);
    rxPktDone = 1; step();
    check("R7 full", 32'(rxFull), 1);
    push(8'h99);
    check("R7 drop while full", 32'(rxLeft), 4);
    rd(1'b1);
    check("R8 wide data", 32'(rdData), 32'h1110);
    check("R8 wide left", 32'(rxLeft), 2);
    rd(1'b0);
    check("R8 narrow data", 32'(rdData), 32'h0012);
    check("R8 narrow left", 32'(rxLeft), 1);
    rd(1'b1);
    check("R9 last byte", 32'(rdData), 32'h0013);
    check("R9 empty flag", 32'(rxFull), 0);
    check("R9 left", 32'(rxLeft), 0);
    rd(1'b1);
    check("R10 empty read data", 32'(rdData), 0);
    check("R10 empty read left", 32'(rxLeft), 0);
    rxPktDone = 1; step();
    check("R7 zero-byte done", 32'(rxFull), 0);

    push(8'h20); push(8'h21); push(8'h22);
    rxPktDone = 1; step();
    rd(1'b0);
    check("R8 second packet", 32'(rdData), 32'h0020);
    check("R8 second left", 32'(rxLeft), 2);
    clearCmd = 1; step();
    check("R11 cleared full", 32'(rxFull), 0);
    check("R11 cleared left", 32'(rxLeft), 0);
    check("R11 tx count kept", 32'(txCount), 1);
    check("R11 tx valid kept", 32'(txValid), 0);
    rd(1'b1);
    check("R10 read after clear", 32'(rdData), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule